// File: doc/BRIEF.md
# Dual-I/O Serial Flash Execute-in-Place Read Controller

This block sits between a host that wants bytes from a serial NOR flash and the flash's four-wire-plus-two-lane pins. The host pulses a start strobe together with a 24-bit byte address, a byte count and a flag. The flag asks that the flash be left in continuous read mode afterwards. The controller runs one chip-select window with the dual-lane fast read (opcode 0xBB). The address and the mode byte go out two bits per serial clock. It then turns both lanes around and returns the requested bytes one strobe at a time. When CS# has been high for the required gap, it signals completion.

The controller keeps a record of whether the flash is still in continuous read mode. While it is, the next window starts directly with the address, which saves eight serial clocks per access. A host reset leaves the flash's mode unknown. For that reason the first accepted request after reset is preceded by a recovery window: sixteen serial clocks with both lanes held high.

States: IDLE, FLUSH (recovery clocks), CMD (opcode), ADDR, MODE, DATA, GAP (CS# high). Transitions: IDLE to FLUSH on an accepted start while the mode is unknown. IDLE to ADDR on an accepted start while continuous mode is active. IDLE to CMD on any other accepted start. FLUSH to GAP, CMD to ADDR, ADDR to MODE and MODE to DATA happen on the falling SCK edge that ends the phase's last clock. DATA to GAP happens on the falling edge after the last byte. GAP goes to CMD after a recovery window, otherwise to IDLE with the done pulse.

Top module: `dual_xip_reader`

## Requirements
- R1: While reset is held and whenever CS# is high, SCK is low, both lane output-enables are 0 and neither the byte strobe nor done is asserted.
- R2: One SCK period lasts SCK_DIV system clocks, with SCK_DIV/2 high. Lane outputs and output-enables change only while SCK is low.
- R3: The first accepted request after reset is preceded by a separate CS# window of exactly 16 SCK clocks in which both lanes are driven and read 1 on every rising edge.
- R4: A command phase drives 0xBB on IO0 only, MSB first, one bit per clock over 8 clocks, with IO1 released.
- R5: The address phase takes 12 clocks. Each clock carries two address bits, the higher bit on IO1 and the lower on IO0, starting with A23/A22.
- R6: The mode byte follows in 4 clocks with the same lane mapping. It is 0x20 (bits 5..4 = 10) when the continuous flag was set with the request, else 0x00.
- R7: From the falling edge that ends the mode byte until CS# rises, both lane enables are 0. Data are sampled on rising edges as pairs (7,6),(5,4),(3,2),(1,0), with IO1 as the higher bit. Exactly the requested number of bytes is strobed, one system clock per byte.
- R8: After a window sent with mode 0x20, the next window omits the command (16 header clocks). After one sent with 0x00, it includes it (24 header clocks).
- R9: CS# stays high for at least 2*SCK_DIV system clocks between windows. Done pulses for one clock, with CS# high, after that gap.
- R10: A start is ignored while a transfer is in progress or when the byte count is 0. No window opens and no done pulse follows.
- R11: Asserting reset again makes the mode unknown, so the next request is again preceded by the 16-clock recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Request strobe, one clock |
| rd_addr | input | 24 | Start byte address |
| rd_len | input | LEN_W | Bytes to read (0 ignored) |
| rd_keep_cm | input | 1 | Leave flash in continuous read mode after this access |
| rd_byte_vld | output | 1 | One-clock strobe per returned byte |
| rd_byte | output | 8 | Returned byte, valid with the strobe |
| rd_done | output | 1 | One-clock completion pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_o | output | 2 | Lane output values, bit 1 = IO1 |
| spi_io_oe | output | 2 | Lane output enables |
| spi_io_i | input | 2 | Lane input values |

## Verification
The embedded properties watch, on every cycle, the SCK idle level, the holding of lane values while SCK is high, the release of both lanes around each received byte, and the single-cycle strobes. They also watch the CS# gap length and the command skip that follows from the continuous-mode flag. What the bits on the wire mean can only be shown by the bench's flash model, which decodes the serial stream against its own copy of the mode state: the recovery pattern, the opcode, the address and mode values, the returned data and the correct header length in each window. The same holds for ignored starts and the effect of a second reset.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_GAP
    } xip_state_e;

    localparam logic [7:0] DUAL_READ_OP = 8'hBB;
    localparam logic [7:0] MODE_HOLD    = 8'h20;
    localparam logic [7:0] MODE_LEAVE   = 8'h00;

    localparam int FLUSH_CLKS = 16;
    localparam int OP_CLKS    = 8;
    localparam int ADDR_CLKS  = 12;
    localparam int MODE_CLKS  = 4;
    localparam int SLOT_W     = $clog2(FLUSH_CLKS);

    // index of the final serial clock of a fixed-length phase
    function automatic logic [SLOT_W-1:0] last_slot(input xip_state_e s);
        case (s)
            ST_FLUSH: return SLOT_W'(FLUSH_CLKS - 1);
            ST_CMD:   return SLOT_W'(OP_CLKS - 1);
            ST_ADDR:  return SLOT_W'(ADDR_CLKS - 1);
            ST_MODE:  return SLOT_W'(MODE_CLKS - 1);
            default:  return '0;
        endcase
    endfunction

    function automatic logic window_open(input xip_state_e s);
        return (s == ST_FLUSH) || (s == ST_CMD) || (s == ST_ADDR) ||
               (s == ST_MODE)  || (s == ST_DATA);
    endfunction

endpackage

// File: rtl/dxr_sck_gen.sv
module dxr_sck_gen #(
    parameter int SCK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          edge_now;

    assign edge_now = run && (cnt == CW'(HALF - 1));
    assign rise     = edge_now && !sck;
    assign fall     = edge_now && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (edge_now) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dxr_tx_shift.sv
module dxr_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic [1:0]   pair
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '0;
        else if (load)
            sh <= load_val;
        else if (shift)
            sh <= {sh[W-3:0], 2'b00};
    end

    assign pair = sh[W-1:W-2];

endmodule

// File: rtl/dxr_rx_deser.sv
module dxr_rx_deser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [1:0] lanes,
    output logic       byte_vld,
    output logic [7:0] byte_q,
    output logic       byte_end
);
    logic [5:0] acc;
    logic [1:0] pair;

    assign byte_end = take && (pair == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            pair     <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (clear) begin
                pair <= '0;
            end else if (take) begin
                acc  <= {acc[3:0], lanes};
                pair <= pair + 2'd1;
                if (pair == 2'd3) begin
                    byte_vld <= 1'b1;
                    byte_q   <= {acc, lanes};
                end
            end
        end
    end

    // R7: a byte strobe never lasts more than one cycle
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

endmodule

// File: rtl/dual_xip_reader.sv
module dual_xip_reader
    import dxr_pkg::*;
#(
    parameter int SCK_DIV = 4,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic [23:0]      rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    input  logic             rd_keep_cm,
    output logic             rd_byte_vld,
    output logic [7:0]       rd_byte,
    output logic             rd_done,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic [1:0]       spi_io_o,
    output logic [1:0]       spi_io_oe,
    input  logic [1:0]       spi_io_i
);
    localparam int GAP_CYC = 2 * SCK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int TX_W    = 24 + 8;

    xip_state_e        state, state_nx;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  left;
    logic              keep_q;
    logic              cm_on;
    logic              cm_unknown;
    logic              after_flush;
    logic [GW-1:0]     gap_cnt;
    logic              done_q;

    logic              run, sck_q, sck_rise, sck_fall;
    logic              accept, phase_end, gap_end, data_end, byte_end;
    logic [1:0]        tx_pair;

    assign run       = window_open(state);
    assign accept    = (state == ST_IDLE) && rd_start && (rd_len != '0);
    assign phase_end = sck_fall && (slot == last_slot(state));
    assign gap_end   = (state == ST_GAP) && (gap_cnt == GW'(GAP_CYC - 1));
    assign data_end  = (state == ST_DATA) && sck_fall && (left == '0);

    dxr_sck_gen #(.SCK_DIV(SCK_DIV)) i_sck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sck  (sck_q),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    dxr_tx_shift #(.W(TX_W)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val({rd_addr, rd_keep_cm ? MODE_HOLD : MODE_LEAVE}),
        .shift   (sck_fall && ((state == ST_ADDR) || (state == ST_MODE))),
        .pair    (tx_pair)
    );

    dxr_rx_deser i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .take    (sck_rise && (state == ST_DATA)),
        .lanes   (spi_io_i),
        .byte_vld(rd_byte_vld),
        .byte_q  (rd_byte),
        .byte_end(byte_end)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)
                          state_nx = cm_unknown ? ST_FLUSH :
                                     (cm_on ? ST_ADDR : ST_CMD);
            ST_FLUSH: if (phase_end) state_nx = ST_GAP;
            ST_CMD:   if (phase_end) state_nx = ST_ADDR;
            ST_ADDR:  if (phase_end) state_nx = ST_MODE;
            ST_MODE:  if (phase_end) state_nx = ST_DATA;
            ST_DATA:  if (data_end)  state_nx = ST_GAP;
            ST_GAP:   if (gap_end)   state_nx = after_flush ? ST_CMD : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // phase bookkeeping and mode tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot        <= '0;
            left        <= '0;
            keep_q      <= 1'b0;
            cm_on       <= 1'b0;
            cm_unknown  <= 1'b1;
            after_flush <= 1'b0;
            gap_cnt     <= '0;
            done_q      <= 1'b0;
        end else begin
            if (state_nx != state)
                slot <= '0;
            else if (sck_fall)
                slot <= slot + 1'b1;

            if (accept) begin
                left   <= rd_len;
                keep_q <= rd_keep_cm;
            end else if (byte_end) begin
                left <= left - 1'b1;
            end

            if ((state == ST_FLUSH) && phase_end) begin
                cm_unknown  <= 1'b0;
                cm_on       <= 1'b0;
                after_flush <= 1'b1;
            end else if (data_end) begin
                cm_on <= keep_q;
            end else if (gap_end) begin
                after_flush <= 1'b0;
            end

            if ((state == ST_GAP) && !gap_end)
                gap_cnt <= gap_cnt + 1'b1;
            else
                gap_cnt <= '0;

            done_q <= gap_end && !after_flush;
        end
    end

    // pin outputs
    always_comb begin
        spi_io_o  = 2'b00;
        spi_io_oe = 2'b00;
        unique case (state)
            ST_FLUSH: begin
                spi_io_o  = 2'b11;
                spi_io_oe = 2'b11;
            end
            ST_CMD: begin
                spi_io_o  = {1'b0, DUAL_READ_OP[3'd7 - slot[2:0]]};
                spi_io_oe = 2'b01;
            end
            ST_ADDR, ST_MODE: begin
                spi_io_o  = tx_pair;
                spi_io_oe = 2'b11;
            end
            default: begin
                spi_io_o  = 2'b00;
                spi_io_oe = 2'b00;
            end
        endcase
    end

    assign spi_sck  = sck_q;
    assign spi_cs_n = !run;
    assign rd_done  = done_q;

    // ---------------- assertions ----------------
    logic [GW-1:0] cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_hi_cnt <= GW'(GAP_CYC);
        else if (!spi_cs_n)
            cs_hi_cnt <= '0;
        else if (cs_hi_cnt != GW'(GAP_CYC))
            cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    // R1: mode-0 idle level of the serial clock
    p_idle_sck_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && (spi_io_oe == 2'b00)));

    // R2: lane values are held while the flash may sample them
    p_lanes_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> ($stable(spi_io_o) && $stable(spi_io_oe)));

    // R7: lanes are released whenever a byte is delivered
    p_released_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte_vld |-> (spi_io_oe == 2'b00) && !spi_cs_n);

    // R8: an active continuous mode skips the opcode phase
    p_skip_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cm_on && !cm_unknown) |=> (state == ST_ADDR));

    // R9: chip select high time between windows
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (cs_hi_cnt == GW'(GAP_CYC)));

    // R9: single-cycle completion pulse with the select released
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> spi_cs_n ##1 !rd_done);

endmodule

// File: tb/test_dual_xip_reader.sv
`timescale 1ns/1ps
module test_dual_xip_reader;
    localparam int SCK_DIV = 4;
    localparam int LEN_W   = 16;
    localparam int GAP_CYC = 2 * SCK_DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_start = 1'b0;
    logic [23:0]      rd_addr = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic             rd_keep_cm = 1'b0;
    logic             rd_byte_vld;
    logic [7:0]       rd_byte;
    logic             rd_done;
    logic             spi_sck, spi_cs_n;
    logic [1:0]       spi_io_o, spi_io_oe, spi_io_i;

    logic             fl_oe = 1'b0;
    logic [1:0]       fl_out = 2'b00;

    always #2 clk = ~clk;

    assign spi_io_i[0] = spi_io_oe[0] ? spi_io_o[0] : (fl_oe ? fl_out[0] : 1'b1);
    assign spi_io_i[1] = spi_io_oe[1] ? spi_io_o[1] : (fl_oe ? fl_out[1] : 1'b1);

    dual_xip_reader #(.SCK_DIV(SCK_DIV), .LEN_W(LEN_W)) i_dual_xip_reader (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_len(rd_len), .rd_keep_cm(rd_keep_cm), .rd_byte_vld(rd_byte_vld),
        .rd_byte(rd_byte), .rd_done(rd_done), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
        .spi_io_i(spi_io_i)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return {a[6:0], a[7]} ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    bit          fm_cm = 1'b1;   // flash left in continuous mode before host reset
    bit          fm_open = 1'b0;
    bit          fm_hdr_cm;
    int          fm_idx;
    logic [7:0]  fm_cmd;
    logic [23:0] fm_addr;
    logic [7:0]  fm_mode;
    bit          fm_allhigh;
    int          contention = 0;

    int          win_n = 0;
    int          w_clocks [0:31];
    bit          w_cmdp   [0:31];
    logic [7:0]  w_cmd    [0:31];
    logic [23:0] w_addr   [0:31];
    logic [7:0]  w_mode   [0:31];
    bit          w_high   [0:31];

    always @(negedge spi_cs_n) begin
        fm_open    = 1'b1;
        fm_idx     = 0;
        fm_hdr_cm  = fm_cm;
        fm_cmd     = '0;
        fm_addr    = '0;
        fm_mode    = '0;
        fm_allhigh = 1'b1;
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            int off;
            off = fm_hdr_cm ? fm_idx + 8 : fm_idx;
            if (spi_io_oe != 2'b11 || spi_io_i != 2'b11) fm_allhigh = 1'b0;
            if (off < 8)       fm_cmd  = {fm_cmd[6:0], spi_io_i[0]};
            else if (off < 20) fm_addr = {fm_addr[21:0], spi_io_i};
            else if (off < 24) fm_mode = {fm_mode[5:0], spi_io_i};
            else if (spi_io_oe != 2'b00) contention++;
            fm_idx++;
        end
    end

    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            int off;
            off = fm_hdr_cm ? fm_idx + 8 : fm_idx;
            if (off >= 24 && (fm_hdr_cm || fm_cmd == 8'hBB)) begin
                int p;
                logic [7:0] b;
                p = off - 24;
                b = mem_byte(fm_addr + 24'(p / 4));
                fl_out = b[7 - 2 * (p % 4) -: 2];
                fl_oe  = 1'b1;
            end
        end
    end

    always @(posedge spi_cs_n) begin
        if (fm_open) begin
            int off;
            fm_open = 1'b0;
            fl_oe   = 1'b0;
            off = fm_hdr_cm ? fm_idx + 8 : fm_idx;
            if (win_n < 32) begin
                w_clocks[win_n] = fm_idx;
                w_cmdp[win_n]   = !fm_hdr_cm;
                w_cmd[win_n]    = fm_cmd;
                w_addr[win_n]   = fm_addr;
                w_mode[win_n]   = fm_mode;
                w_high[win_n]   = fm_allhigh;
            end
            win_n++;
            if (off >= 24 && (fm_hdr_cm || fm_cmd == 8'hBB))
                fm_cm = (fm_mode[5:4] == 2'b10);
            else if (!fm_hdr_cm)
                fm_cm = 1'b0;
        end
    end

    // ---------------- pin-level monitors ----------------
    int   cs_hi = 1000;
    int   gap_bad = 0;
    int   sck_hi_len = 0;
    int   sck_bad = 0;
    int   stab_bad = 0;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;
    logic [1:0] prev_o = '0, prev_oe = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n && cs_hi < GAP_CYC) gap_bad++;
            if (spi_cs_n) cs_hi++; else cs_hi = 0;
            if (spi_sck && prev_sck && (spi_io_o != prev_o || spi_io_oe != prev_oe))
                stab_bad++;
            if (spi_sck && !prev_sck && (spi_io_o != prev_o || spi_io_oe != prev_oe))
                stab_bad++;
            if (spi_sck) sck_hi_len++;
            else if (prev_sck) begin
                if (sck_hi_len != SCK_DIV / 2) sck_bad++;
                sck_hi_len = 0;
            end
            if (spi_cs_n && spi_sck) sck_bad++;
        end else begin
            cs_hi = 1000;
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
        prev_o   = spi_io_o;
        prev_oe  = spi_io_oe;
    end

    // ---------------- host tasks ----------------
    task automatic pulse_start(input logic [23:0] a, input int n, input bit keep);
        @(negedge clk);
        rd_start   = 1'b1;
        rd_addr    = a;
        rd_len     = LEN_W'(n);
        rd_keep_cm = keep;
        @(negedge clk);
        rd_start   = 1'b0;
    endtask

    task automatic collect(input logic [23:0] a, output int got, output int bad,
                           output bit done_seen);
        got = 0;
        bad = 0;
        done_seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (rd_byte_vld) begin
                if (rd_byte != mem_byte(a + 24'(got))) begin
                    bad++;
                    $display("  byte %0d: got %0h want %0h", got, rd_byte,
                             mem_byte(a + 24'(got)));
                end
                got++;
            end
            if (rd_done) begin
                done_seen = 1'b1;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] len;
        logic        keep;
        logic        with_cmd;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{24'h123456, 16'd3, 1'b1, 1'b1},
        '{24'hABCDEF, 16'd2, 1'b1, 1'b0},
        '{24'h000FFE, 16'd4, 1'b0, 1'b0},
        '{24'hFFFFFE, 16'd5, 1'b0, 1'b1},
        '{24'h5A5A5A, 16'd1, 1'b1, 1'b1},
        '{24'h000000, 16'd1, 1'b0, 1'b0},
        '{24'h3C3C3C, 16'd2, 1'b1, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int got, bad, w0, dn;
        bit done_seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck in reset", spi_sck, 0);
        check(spi_io_oe == 2'b00, "R1", "oe in reset", spi_io_oe, 0);
        check(!rd_byte_vld && !rd_done, "R1", "strobes in reset",
              {rd_byte_vld, rd_done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(spi_cs_n && !spi_sck, "R1", "idle after reset", {spi_cs_n, spi_sck}, 2);

        // table of reads
        for (int i = 0; i < 7; i++) begin
            int base, hdr;
            w0 = win_n;
            pulse_start(VECS[i].addr, int'(VECS[i].len), VECS[i].keep);
            collect(VECS[i].addr, got, bad, done_seen);
            repeat (2) @(negedge clk);
            check(done_seen, "R9", "done pulse", done_seen, 1);
            check(got == int'(VECS[i].len), "R7", "byte count", got, VECS[i].len);
            check(bad == 0, "R7", "byte values", bad, 0);
            check(win_n - w0 == (i == 0 ? 2 : 1), "R3", "window count", win_n - w0,
                  i == 0 ? 2 : 1);
            if (i == 0) begin
                check(w_clocks[w0] == 16, "R3", "recovery clocks", w_clocks[w0], 16);
                check(w_high[w0], "R3", "recovery lanes high", w_high[w0], 1);
            end
            base = win_n - 1;
            hdr  = VECS[i].with_cmd ? 24 : 16;
            check(w_cmdp[base] == VECS[i].with_cmd, "R8", "opcode present",
                  w_cmdp[base], VECS[i].with_cmd);
            if (VECS[i].with_cmd)
                check(w_cmd[base] == 8'hBB, "R4", "opcode value", w_cmd[base], 8'hBB);
            check(w_addr[base] == VECS[i].addr, "R5", "address", w_addr[base],
                  VECS[i].addr);
            check(w_mode[base] == (VECS[i].keep ? 8'h20 : 8'h00), "R6", "mode byte",
                  w_mode[base], VECS[i].keep ? 8'h20 : 8'h00);
            check(w_clocks[base] == hdr + 4 * int'(VECS[i].len), "R8", "window clocks",
                  w_clocks[base], hdr + 4 * int'(VECS[i].len));
        end

        // R10: start during a transfer is ignored
        w0 = win_n;
        dn = 0;
        pulse_start(24'h0F1E2D, 3, 1'b1);
        repeat (30) @(negedge clk);
        rd_start = 1'b1; rd_addr = 24'h777777; rd_len = 16'd1; rd_keep_cm = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
        collect(24'h0F1E2D, got, bad, done_seen);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (rd_done) dn++;
        end
        check(win_n - w0 == 1, "R10", "busy start windows", win_n - w0, 1);
        check(w_addr[win_n - 1] == 24'h0F1E2D, "R10", "busy start address",
              w_addr[win_n - 1], 24'h0F1E2D);
        check(got == 3 && bad == 0, "R10", "busy start bytes", got, 3);
        check(done_seen && dn == 0, "R10", "busy start extra done", dn, 0);

        // R10: zero length request is ignored
        w0 = win_n;
        dn = 0;
        pulse_start(24'h111111, 0, 1'b0);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (rd_done) dn++;
        end
        check(win_n == w0, "R10", "zero length windows", win_n - w0, 0);
        check(dn == 0, "R10", "zero length done", dn, 0);

        // R11: second host reset forces a new recovery window
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(spi_cs_n && spi_io_oe == 2'b00, "R1", "cs_n and oe in second reset",
              {spi_cs_n, spi_io_oe}, 4);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        w0 = win_n;
        pulse_start(24'h246801, 2, 1'b0);
        collect(24'h246801, got, bad, done_seen);
        repeat (2) @(negedge clk);
        check(win_n - w0 == 2, "R11", "windows after reset", win_n - w0, 2);
        check(w_clocks[w0] == 16 && w_high[w0], "R11", "recovery window",
              w_clocks[w0], 16);
        check(w_cmdp[w0 + 1] && w_cmd[w0 + 1] == 8'hBB, "R11", "opcode after recovery",
              w_cmd[w0 + 1], 8'hBB);
        check(got == 2 && bad == 0 && done_seen, "R11", "data after recovery", got, 2);

        // accumulated pin-level checks
        check(sck_bad == 0, "R2", "sck high width / idle level", sck_bad, 0);
        check(stab_bad == 0, "R2", "lane change while sck high", stab_bad, 0);
        check(gap_bad == 0, "R9", "cs_n gap too short", gap_bad, 0);
        check(contention == 0, "R7", "lanes driven in data phase", contention, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule